// File: doc/BRIEF.md
# Haar Line Transform Engine

This block runs one forward level of the Haar wavelet over a single line of an image that sits in a word-wide, single-port memory. The line is either a row, with samples at consecutive addresses, or a column, with samples one image-row stride apart. The engine walks the line two samples at a time and replaces each pair with an average (low) coefficient and a difference (high) coefficient. It uses only arithmetic halving and an adder/subtractor, with no multiplier.

A controller that sequences rows, columns and levels pulses `start` with the line's base address, its sample count and its orientation. The engine then owns the memory port. It reads both samples of a pair before writing anything, so the results overwrite the line in place. When the last pair has been written, it raises `done` for one cycle.

Top module: `haar_line_engine`

## Requirements
- R1: For a pair (a, b) of 8-bit two's-complement samples, the word written to the pair's first element is the low coefficient (a>>>1)+(b>>>1), kept to 8 bits.
- R2: The word written to the pair's second element is the high coefficient (a>>>1)-(b>>>1), kept to 8 bits.
- R3: The halving is an arithmetic shift that copies the sign bit into the vacated top bit. For example, 0xFD halves to 0xFE and 0x80 halves to 0xC0.
- R4: Pairs do not overlap. Pair i uses line elements 2i and 2i+1, and its low and high results go back to elements 2i and 2i+1.
- R5: With `vertical`=0, line element k sits at address `baseAddr`+k.
- R6: With `vertical`=1, line element k sits at address `baseAddr`+k·ROW_STRIDE (default 16). Addresses between the column's elements are not written.
- R7: `done` is high for exactly one cycle per accepted start.
- R8: For P = floor(`lineLen`/2) ≥ 1 pairs, `done` rises on the (5·P+1)-th rising edge, counting the edge that samples `start` as the first. Each pair takes two read cycles and one capture cycle, then writes low and high in two consecutive cycles.
- R9: A `start` pulse while a line is in progress is ignored: the running line finishes on its original timing, and the new base address is not touched.
- R10: With an odd `lineLen`, the last sample is neither written nor changed. With `lineLen` of 0 or 1, nothing is written and `done` rises on the first edge after the sampling edge (count 1).
- R11: After reset, `done` and `memWe` are low until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to transform a line; accepted only when idle |
| baseAddr | input | ADDR_W | Address of line element 0 |
| lineLen | input | LEN_W | Number of samples in the line |
| vertical | input | 1 | 0 = row (step 1), 1 = column (step ROW_STRIDE) |
| done | output | 1 | One-cycle pulse after the last write of the line |
| memAddr | output | ADDR_W | Memory address for the read or write |
| memRdData | input | DATA_W | Read data, valid one cycle after the address |
| memWrData | output | DATA_W | Write data |
| memWe | output | 1 | Write enable |

## Verification
On every cycle, the checker enforces the shape of the memory traffic. Writes come in back-to-back pairs, each preceded by three non-writing cycles and followed by a non-writing cycle. `done` never coincides with a write and never lasts two cycles. The coefficient values, including the sign-extended halving at the extreme sample values, and the addresses for the row and column strides can only be shown by the bench's scenarios. The same holds for the start-to-done latency, the untouched odd sample, and the ignored start during a busy line; the bench compares memory contents and cycle counts against values worked out independently.

// File: rtl/haar_pkg.sv
package haar_pkg;
  typedef struct packed {
    logic load;     // capture base, length and orientation
    logic capA;     // latch first sample from read data
    logic capB;     // latch second sample from read data
    logic selB;     // address the second element of the pair
    logic we;       // write the selected coefficient
    logic selHigh;  // choose the high coefficient for writing
    logic advance;  // move on to the next pair
  } haarStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDA, ST_RDB, ST_CAP, ST_WRL, ST_WRH, ST_FIN
  } haarState_t;
endpackage

// File: rtl/haar_dp.sv
module haar_dp #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10,
  parameter int LEN_W = 6,
  parameter int ROW_STRIDE = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  haar_pkg::haarStrobes_t strobes,
  input  logic [ADDR_W-1:0]     baseAddr,
  input  logic [LEN_W-1:0]      lineLen,
  input  logic                  vertical,
  input  logic [DATA_W-1:0]     memRdData,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]     memWrData,
  output logic                  emptyLine,
  output logic                  lastPair
);
  localparam int PAIR_W = (LEN_W > 1) ? LEN_W - 1 : 1;
  localparam logic [ADDR_W-1:0] COL_STEP = ADDR_W'(ROW_STRIDE);
  localparam logic [ADDR_W-1:0] ROW_STEP = ADDR_W'(1);

  logic [ADDR_W-1:0] addrA, step;
  logic [PAIR_W-1:0] pairsLeft;
  logic [DATA_W-1:0] sampA, sampB;
  logic [DATA_W-1:0] halfA, halfB, lowCoef, highCoef;
  logic [ADDR_W-1:0] addrB;

  assign addrB = addrA + step;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrA     <= '0;
      step      <= ROW_STEP;
      pairsLeft <= '0;
      sampA     <= '0;
      sampB     <= '0;
    end else begin
      if (strobes.load) begin
        addrA     <= baseAddr;
        step      <= vertical ? COL_STEP : ROW_STEP;
        pairsLeft <= PAIR_W'(lineLen >> 1);
      end else if (strobes.advance) begin
        addrA     <= addrA + (step << 1);
        pairsLeft <= pairsLeft - 1'b1;
      end
      if (strobes.capA) sampA <= memRdData;
      if (strobes.capB) sampB <= memRdData;
    end
  end

  // sign-replicating halving of each latched sample
  assign halfA    = {sampA[DATA_W-1], sampA[DATA_W-1:1]};
  assign halfB    = {sampB[DATA_W-1], sampB[DATA_W-1:1]};
  assign lowCoef  = halfA + halfB;
  assign highCoef = halfA - halfB;

  assign memAddr   = strobes.selB ? addrB : addrA;
  assign memWrData = strobes.selHigh ? highCoef : lowCoef;
  assign emptyLine = (lineLen >> 1) == '0;
  assign lastPair  = pairsLeft == PAIR_W'(1);
endmodule

// File: rtl/haar_ctrl.sv
module haar_ctrl (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   emptyLine,
  input  logic                   lastPair,
  output haar_pkg::haarStrobes_t strobes,
  output logic                   done
);
  import haar_pkg::*;

  haarState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // outputs depend on state and on the start/status inputs
  always_comb begin
    strobes   = '0;
    nextState = state;
    case (state)
      ST_IDLE: if (start) begin
        strobes.load = 1'b1;
        nextState    = emptyLine ? ST_FIN : ST_RDA;
      end
      ST_RDA: nextState = ST_RDB;
      ST_RDB: begin
        strobes.selB = 1'b1;
        strobes.capA = 1'b1;
        nextState    = ST_CAP;
      end
      ST_CAP: begin
        strobes.capB = 1'b1;
        nextState    = ST_WRL;
      end
      ST_WRL: begin
        strobes.we = 1'b1;
        nextState  = ST_WRH;
      end
      ST_WRH: begin
        strobes.we      = 1'b1;
        strobes.selB    = 1'b1;
        strobes.selHigh = 1'b1;
        strobes.advance = 1'b1;
        nextState       = lastPair ? ST_FIN : ST_RDA;
      end
      ST_FIN:  nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign done = state == ST_FIN;
endmodule

// File: rtl/haar_line_engine.sv
module haar_line_engine #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10,
  parameter int LEN_W = 6,
  parameter int ROW_STRIDE = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [LEN_W-1:0]  lineLen,
  input  logic              vertical,
  output logic              done,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] memWrData,
  output logic              memWe
);
  haar_pkg::haarStrobes_t strobes;
  logic emptyLine, lastPair;

  haar_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .emptyLine(emptyLine),
    .lastPair(lastPair), .strobes(strobes), .done(done)
  );

  haar_dp #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .ROW_STRIDE(ROW_STRIDE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .baseAddr(baseAddr),
    .lineLen(lineLen), .vertical(vertical), .memRdData(memRdData),
    .memAddr(memAddr), .memWrData(memWrData), .emptyLine(emptyLine),
    .lastPair(lastPair)
  );

  assign memWe = strobes.we;
endmodule

// File: rtl/haar_line_chk.sv
module haar_line_chk (
  input logic clk,
  input logic rstN,
  input logic done,
  input logic memWe
);
  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R11
  done_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !memWe);

  // R4
  write_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !$past(memWe)) |=> memWe);

  // R4
  write_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && $past(memWe)) |=> !memWe);

  // R8
  read_before_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWe) |-> (!$past(memWe, 1) && !$past(memWe, 2) && !$past(memWe, 3)));
endmodule

bind haar_line_engine haar_line_chk u_chk (
  .clk(clk), .rstN(rstN), .done(done), .memWe(memWe)
);

// File: tb/test_haar_line_engine.sv
`timescale 1ns/1ps
module test_haar_line_engine;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 10;
  localparam int LEN_W = 6;
  localparam int STRIDE = 16;
  localparam int NVEC = 8;

  // {a, b, expected low, expected high}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h0A, 8'h04, 8'h07, 8'h03},
    {8'hFD, 8'h05, 8'h00, 8'hFC},
    {8'hFF, 8'hFF, 8'hFE, 8'h00},
    {8'h7F, 8'h7F, 8'h7E, 8'h00},
    {8'h80, 8'h80, 8'h80, 8'h00},
    {8'h7F, 8'h80, 8'hFF, 8'h7F},
    {8'h80, 8'h7F, 8'hFF, 8'h81},
    {8'h07, 8'h03, 8'h04, 8'h02}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [ADDR_W-1:0] baseAddr = '0;
  logic [LEN_W-1:0] lineLen = '0;
  logic vertical = 1'b0;
  logic done, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [DATA_W-1:0] memRdData, memWrData;

  logic [DATA_W-1:0] mem [1<<ADDR_W];
  int wrCount = 0;
  int errors = 0;
  int checks = 0;
  int lat;

  always #10 clk = ~clk;

  haar_line_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
    .ROW_STRIDE(STRIDE)) i_haar_line_engine (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .lineLen(lineLen), .vertical(vertical), .done(done), .memAddr(memAddr),
    .memRdData(memRdData), .memWrData(memWrData), .memWe(memWe)
  );

  always @(posedge clk) begin
    if (memWe) begin
      mem[memAddr] <= memWrData;
      wrCount <= wrCount + 1;
    end
    memRdData <= mem[memAddr];
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fillMem();
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = DATA_W'(i ^ 8'h33);
  endtask

  // launch a line and return the count of edges until done (sampling edge = 1)
  task automatic runLine(input int base, input int len, input logic vert,
                         output int count);
    @(negedge clk);
    baseAddr = ADDR_W'(base);
    lineLen  = LEN_W'(len);
    vertical = vert;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    count = 1;
    while (!done && count < 2000) begin
      @(negedge clk);
      count++;
    end
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog: actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int w0;
    fillMem();
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 done in reset", int'(done), 0);
    check("R11 memWe in reset", int'(memWe), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 done after reset", int'(done), 0);

    // horizontal line of all vectors: R1 R2 R3 R4 R5 R8
    for (int v = 0; v < NVEC; v++) begin
      mem[10'h040 + 2*v]     = VEC[v][31:24];
      mem[10'h040 + 2*v + 1] = VEC[v][23:16];
    end
    runLine('h040, 2*NVEC, 1'b0, lat);
    check("R8 horizontal latency", lat, 5*NVEC + 1);
    for (int v = 0; v < NVEC; v++) begin
      check("R1 R3 R5 low coefficient", int'(mem[10'h040 + 2*v]), int'(VEC[v][15:8]));
      check("R2 R3 R4 high coefficient", int'(mem[10'h040 + 2*v + 1]), int'(VEC[v][7:0]));
    end
    check("R5 next address untouched", int'(mem[10'h050]), int'(8'h50 ^ 8'h33));
    @(negedge clk);
    check("R7 done single cycle", int'(done), 0);

    // vertical column: R6
    fillMem();
    for (int v = 0; v < NVEC; v++) begin
      mem[3 + STRIDE*(2*v)]     = VEC[v][31:24];
      mem[3 + STRIDE*(2*v + 1)] = VEC[v][23:16];
    end
    runLine(3, 2*NVEC, 1'b1, lat);
    check("R8 vertical latency", lat, 5*NVEC + 1);
    for (int v = 0; v < NVEC; v++) begin
      check("R6 column low", int'(mem[3 + STRIDE*(2*v)]), int'(VEC[v][15:8]));
      check("R6 column high", int'(mem[3 + STRIDE*(2*v + 1)]), int'(VEC[v][7:0]));
    end
    check("R6 gap address untouched", int'(mem[4]), int'(8'h04 ^ 8'h33));
    check("R6 gap address untouched", int'(mem[3 + 1 + STRIDE]), int'(8'h14 ^ 8'h33));

    // odd length: R10
    fillMem();
    mem['h100] = 8'h10; mem['h101] = 8'h06;
    mem['h102] = 8'hF0; mem['h103] = 8'h08;
    mem['h104] = 8'hAB;
    w0 = wrCount;
    runLine('h100, 5, 1'b0, lat);
    check("R10 odd latency", lat, 11);
    check("R10 odd write count", wrCount - w0, 4);
    check("R1 odd low0", int'(mem['h100]), 'h0B);
    check("R2 odd high1", int'(mem['h103]), 'hF4);
    check("R10 last sample untouched", int'(mem['h104]), 'hAB);

    // empty lines: R10
    w0 = wrCount;
    runLine('h120, 0, 1'b0, lat);
    check("R10 len0 latency", lat, 1);
    runLine('h120, 1, 1'b1, lat);
    check("R10 len1 latency", lat, 1);
    check("R10 empty write count", wrCount - w0, 0);
    check("R10 len1 sample untouched", int'(mem['h120]), int'(8'h20 ^ 8'h33));

    // start while busy: R9
    fillMem();
    @(negedge clk);
    baseAddr = 'h200; lineLen = 8; vertical = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (6) begin @(negedge clk); lat++; end
    baseAddr = 'h300; start = 1'b1;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 2000) begin @(negedge clk); lat++; end
    check("R9 busy latency unchanged", lat, 21);
    check("R9 new base untouched", int'(mem['h300]), int'(8'h00 ^ 8'h33));
    check("R9 original line written", int'(mem['h200]),
          int'(8'(({1'b0, 7'h19}) + ({1'b0, 7'h19}))));
    repeat (3) @(negedge clk);
    check("R7 no second done", int'(done), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule